// File: doc/BRIEF.md
# Priority interrupt level selector

This block turns a set of level-sensitive interrupt sources into one prioritised request for a processor core. External level lines and a software interrupt register merge into one pending vector, with one pending bit per priority level. Timer-match flags in the software register are folded onto a fixed level. The block then picks the highest pending level that lies strictly above the core's current priority threshold. It drives a registered request, together with the trap code and the level index of the winner.

Three conditions can stop a selection. A vector interrupt that is being serviced outranks every level interrupt and freezes the selector. If interrupts are globally disabled, or if no level exceeds the threshold, the request is withdrawn. While the core is already inside an external-interrupt trap with a higher code, a lower new selection is held back. Taking the trap and saving state are left to the core.

Top module: `prio_lvl_sel`

## Requirements
- R1: The pending vector is the bitwise OR of `ext_lvl` and `soft_reg[15:0]`, where `soft_reg[0]` (a timer-match flag) takes no part in that OR. Level 0 never wins, because it can never be above a threshold.
- R2: If either timer-match flag `soft_reg[0]` or `soft_reg[16]` is set, pending bit 14 is forced on.
- R3: While `vec_busy` is high, `irq_req`, `irq_tt` and `irq_lvl` keep their values on every clock edge, whatever the other inputs do.
- R4: When no pending bit lies above `thr` (pending vector below 2 shifted left by `thr`), and `vec_busy` is low, the next edge clears `irq_req`, `irq_lvl` and `irq_tt` to 0. When `thr` is 15 this always happens.
- R5: The winning level is the highest set pending bit that is strictly greater than `thr`.
- R6: The trap code of level n is the base code 0x40 ORed with n, so level 12 gives 0x4C.
- R7: When `trap_lvl` is nonzero, `svc_tt & 0x1F0` equals 0x40, and `svc_tt` is greater than the new code, the outputs keep their values. An in-service code equal to the new code, or outside the 0x40 group, does not hold the selection back.
- R8: When `glb_en` is low and `vec_busy` is low, the next edge clears `irq_req`, `irq_lvl` and `irq_tt` to 0.
- R9: `irq_req` rises only on an edge where the trap code loaded differs from the recorded one. If the selected code equals the recorded code, all outputs keep their values.
- R10: During reset, `irq_req`, `irq_tt` and `irq_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_lvl | input | 16 | External interrupt level lines, bit n for level n |
| soft_reg | input | 17 | Software interrupt register; bits 0 and 16 are timer-match flags |
| thr | input | 4 | Current processor priority threshold |
| glb_en | input | 1 | Global interrupt enable |
| vec_busy | input | 1 | A vector interrupt is pending or in service |
| trap_lvl | input | 3 | Current trap nesting level |
| svc_tt | input | 9 | Trap code currently in service |
| irq_req | output | 1 | Registered interrupt request |
| irq_tt | output | 9 | Trap code of the selected level |
| irq_lvl | output | 4 | Index of the selected level |

## Verification
Every decision is registered in one stage, so a wrong recorded trap code shows at the ports on the edge right after the stimulus. A fault of that kind appears as a wrong code or level, as a request that stays high after a disable or threshold clear, or as a stale code that survives when the selection changes. A wrong hold decision, whether from the vector-busy freeze or from the nested-trap gate, shows up as outputs that change or stay frozen one cycle after the input step. The bench therefore checks every output one cycle after each input step.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;

  // Action chosen by the selector for the coming edge
  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_CLEAR = 2'd1,
    SEL_LOAD  = 2'd2
  } sel_act_e;

endpackage

// File: rtl/prio_pend_merge.sv
module prio_pend_merge #(
  parameter int NLVL    = 16,
  parameter int TMR_LVL = 14
) (
  input  logic [NLVL-1:0] ext_lvl,
  input  logic [NLVL:0]   soft_reg,
  output logic [NLVL-1:0] pend
);

  logic             tmr_hit;
  logic [NLVL-1:0]  soft_lvls;
  logic [NLVL-1:0]  tmr_vec;

  // bit 0 of the soft register is a timer flag, not a level request
  assign soft_lvls = {soft_reg[NLVL-1:1], 1'b0};
  assign tmr_hit   = soft_reg[0] | soft_reg[NLVL];
  assign tmr_vec   = tmr_hit ? (NLVL'(1) << TMR_LVL) : '0;
  assign pend      = ext_lvl | soft_lvls | tmr_vec;

endmodule

// File: rtl/prio_lvl_scan.sv
module prio_lvl_scan #(
  parameter int NLVL  = 16,
  localparam int LVL_W = $clog2(NLVL)
) (
  input  logic [NLVL-1:0]  pend,
  input  logic [LVL_W-1:0] thr,
  output logic             hit,
  output logic [LVL_W-1:0] win_lvl
);

  logic [NLVL-1:0] qual;

  // only levels strictly above the threshold qualify
  for (genvar g = 0; g < NLVL; g++) begin : g_qual
    assign qual[g] = pend[g] & (LVL_W'(g) > thr);
  end

  assign hit = |qual;

  // upward scan so the highest qualifying level overwrites lower ones
  always_comb begin
    win_lvl = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (qual[i]) win_lvl = LVL_W'(i);
    end
  end

endmodule

// File: rtl/prio_nest_gate.sv
module prio_nest_gate #(
  parameter int          TT_W     = 9,
  parameter int          TL_W     = 3,
  parameter logic [8:0]  BASE_TT  = 9'h040,
  parameter logic [8:0]  GRP_MASK = 9'h1F0
) (
  input  logic [TL_W-1:0] trap_lvl,
  input  logic [TT_W-1:0] svc_tt,
  input  logic [TT_W-1:0] new_tt,
  output logic            blocked
);

  logic in_trap;
  logic in_grp;
  logic outranks;

  assign in_trap  = |trap_lvl;
  assign in_grp   = (svc_tt & TT_W'(GRP_MASK)) == TT_W'(BASE_TT);
  assign outranks = svc_tt > new_tt;
  assign blocked  = in_trap & in_grp & outranks;

endmodule

// File: rtl/prio_lvl_sel.sv
module prio_lvl_sel
  import prio_sel_pkg::*;
#(
  parameter int         NLVL     = 16,
  parameter int         TMR_LVL  = 14,
  parameter int         TT_W     = 9,
  parameter int         TL_W     = 3,
  parameter logic [8:0] BASE_TT  = 9'h040,
  parameter logic [8:0] GRP_MASK = 9'h1F0,
  localparam int        LVL_W    = $clog2(NLVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLVL-1:0]  ext_lvl,
  input  logic [NLVL:0]    soft_reg,
  input  logic [LVL_W-1:0] thr,
  input  logic             glb_en,
  input  logic             vec_busy,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [TT_W-1:0]  svc_tt,
  output logic             irq_req,
  output logic [TT_W-1:0]  irq_tt,
  output logic [LVL_W-1:0] irq_lvl
);

  logic [NLVL-1:0]  pend;
  logic             hit;
  logic [LVL_W-1:0] win_lvl;
  logic [TT_W-1:0]  new_tt;
  logic             blocked;
  sel_act_e         act;

  logic             req_q,  req_d;
  logic [TT_W-1:0]  tt_q,   tt_d;
  logic [LVL_W-1:0] lvl_q,  lvl_d;
  logic             upd_en;

  prio_pend_merge #(.NLVL(NLVL), .TMR_LVL(TMR_LVL)) u_merge (
    .ext_lvl  (ext_lvl),
    .soft_reg (soft_reg),
    .pend     (pend)
  );

  prio_lvl_scan #(.NLVL(NLVL)) u_scan (
    .pend    (pend),
    .thr     (thr),
    .hit     (hit),
    .win_lvl (win_lvl)
  );

  assign new_tt = TT_W'(BASE_TT) | TT_W'(win_lvl);

  prio_nest_gate #(
    .TT_W(TT_W), .TL_W(TL_W), .BASE_TT(BASE_TT), .GRP_MASK(GRP_MASK)
  ) u_gate (
    .trap_lvl (trap_lvl),
    .svc_tt   (svc_tt),
    .new_tt   (new_tt),
    .blocked  (blocked)
  );

  // decision: vector busy freezes, no qualifier or disable clears
  always_comb begin
    if (vec_busy)            act = SEL_HOLD;
    else if (!hit)           act = SEL_CLEAR;
    else if (!glb_en)        act = SEL_CLEAR;
    else if (blocked)        act = SEL_HOLD;
    else if (new_tt != tt_q) act = SEL_LOAD;
    else                     act = SEL_HOLD;
  end

  // next-state values
  always_comb begin
    upd_en = (act != SEL_HOLD);
    req_d  = 1'b0;
    tt_d   = '0;
    lvl_d  = '0;
    if (act == SEL_LOAD) begin
      req_d = 1'b1;
      tt_d  = new_tt;
      lvl_d = win_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      tt_q  <= '0;
      lvl_q <= '0;
    end else if (upd_en) begin
      req_q <= req_d;
      tt_q  <= tt_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq_req = req_q;
  assign irq_tt  = tt_q;
  assign irq_lvl = lvl_q;

endmodule

// File: rtl/prio_lvl_sel_chk.sv
module prio_lvl_sel_chk #(
  parameter int         NLVL    = 16,
  parameter int         TMR_LVL = 14,
  parameter int         TT_W    = 9,
  parameter int         TL_W    = 3,
  parameter logic [8:0] BASE_TT = 9'h040,
  localparam int        LVL_W   = $clog2(NLVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NLVL-1:0]  ext_lvl,
  input logic [NLVL:0]    soft_reg,
  input logic [LVL_W-1:0] thr,
  input logic             glb_en,
  input logic             vec_busy,
  input logic [TL_W-1:0]  trap_lvl,
  input logic [TT_W-1:0]  svc_tt,
  input logic             irq_req,
  input logic [TT_W-1:0]  irq_tt,
  input logic [LVL_W-1:0] irq_lvl
);

  AST_VEC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_busy |=> ($stable(irq_req) && $stable(irq_tt) && $stable(irq_lvl))); // R3

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && !glb_en) |=> (!irq_req && irq_tt == '0 && irq_lvl == '0)); // R8

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && ext_lvl == '0 && soft_reg == '0) |=> !irq_req); // R4

  AST_CODE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_tt == (TT_W'(BASE_TT) | TT_W'(irq_lvl)))); // R6

  AST_RISE_NEW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (irq_tt != $past(irq_tt))); // R9

  AST_TIMER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && glb_en && (soft_reg[0] || soft_reg[NLVL]) &&
     thr < LVL_W'(TMR_LVL) && trap_lvl == '0)
    |=> (irq_req && irq_lvl >= LVL_W'(TMR_LVL))); // R2

endmodule

bind prio_lvl_sel prio_lvl_sel_chk #(
  .NLVL(NLVL), .TMR_LVL(TMR_LVL), .TT_W(TT_W), .TL_W(TL_W), .BASE_TT(BASE_TT)
) u_chk (.*);

// File: tb/prio_lvl_sel_bench.sv
module prio_lvl_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ext_lvl;
  logic [16:0] soft_reg;
  logic [3:0]  thr;
  logic        glb_en;
  logic        vec_busy;
  logic [2:0]  trap_lvl;
  logic [8:0]  svc_tt;
  logic        irq_req;
  logic [8:0]  irq_tt;
  logic [3:0]  irq_lvl;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  prio_lvl_sel u_prio_lvl_sel (
    .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_reg(soft_reg),
    .thr(thr), .glb_en(glb_en), .vec_busy(vec_busy), .trap_lvl(trap_lvl),
    .svc_tt(svc_tt), .irq_req(irq_req), .irq_tt(irq_tt), .irq_lvl(irq_lvl)
  );

  // compare all three outputs against expectations
  task automatic expect_out(input string tag, input logic e_req,
                            input logic [3:0] e_lvl, input logic [8:0] e_tt);
    n_chk++;
    if (irq_req !== e_req || irq_lvl !== e_lvl || irq_tt !== e_tt) begin
      n_fail++;
      $display("FAIL %s: req=%0b lvl=%0d tt=%h expected req=%0b lvl=%0d tt=%h",
               tag, irq_req, irq_lvl, irq_tt, e_req, e_lvl, e_tt);
    end
  endtask

  // drive at a falling edge, one rising edge loads, sample at next falling edge
  task automatic drive(input logic [15:0] e, input logic [16:0] s,
                       input logic [3:0] t, input logic en, input logic vb,
                       input logic [2:0] tl, input logic [8:0] st);
    @(negedge clk);
    ext_lvl = e; soft_reg = s; thr = t; glb_en = en;
    vec_busy = vb; trap_lvl = tl; svc_tt = st;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ext_lvl = 16'hFFFF; soft_reg = '0; thr = 4'd0; glb_en = 1'b1;
    vec_busy = 1'b0; trap_lvl = '0; svc_tt = '0;
    repeat (3) @(negedge clk);
    expect_out("R10 reset", 1'b0, 4'd0, 9'h000);
    ext_lvl = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R4 idle after reset", 1'b0, 4'd0, 9'h000);
  endtask

  task automatic t_merge();
    drive(16'h0020, 17'h0, 4'd0, 1, 0, 0, 0);
    expect_out("R1 ext level 5", 1'b1, 4'd5, 9'h045);
    drive(16'h0000, 17'h00008, 4'd0, 1, 0, 0, 0);
    expect_out("R1 soft level 3", 1'b1, 4'd3, 9'h043);
    drive(16'h0001, 17'h0, 4'd0, 1, 0, 0, 0);
    expect_out("R1 level 0 never wins", 1'b0, 4'd0, 9'h000);
  endtask

  task automatic t_timer();
    drive(16'h0000, 17'h10000, 4'd0, 1, 0, 0, 0);
    expect_out("R2 upper timer flag", 1'b1, 4'd14, 9'h04E);
    drive(16'h0000, 17'h00001, 4'd0, 1, 0, 0, 0);
    expect_out("R9 same code holds", 1'b1, 4'd14, 9'h04E);
    drive(16'h8000, 17'h00001, 4'd0, 1, 0, 0, 0);
    expect_out("R2 timer below level 15", 1'b1, 4'd15, 9'h04F);
  endtask

  task automatic t_scan();
    drive(16'h1208, 17'h0, 4'd4, 1, 0, 0, 0);
    expect_out("R5 highest of 3,9,12", 1'b1, 4'd12, 9'h04C);
    drive(16'h1208, 17'h0, 4'd12, 1, 0, 0, 0);
    expect_out("R4 equal to threshold", 1'b0, 4'd0, 9'h000);
    drive(16'h1208, 17'h0, 4'd11, 1, 0, 0, 0);
    expect_out("R6 level 12 code", 1'b1, 4'd12, 9'h04C);
    drive(16'h1208, 17'h0, 4'd9, 1, 0, 0, 0);
    expect_out("R5 threshold 9", 1'b1, 4'd12, 9'h04C);
  endtask

  task automatic t_below();
    drive(16'hFFFF, 17'h1FFFF, 4'd15, 1, 0, 0, 0);
    expect_out("R4 threshold 15", 1'b0, 4'd0, 9'h000);
    drive(16'h8000, 17'h0, 4'd14, 1, 0, 0, 0);
    expect_out("R5 level 15 over 14", 1'b1, 4'd15, 9'h04F);
  endtask

  task automatic t_vec();
    drive(16'h0004, 17'h0, 4'd0, 1, 1, 0, 0);
    expect_out("R3 busy holds", 1'b1, 4'd15, 9'h04F);
    drive(16'h0000, 17'h0, 4'd0, 0, 1, 0, 0);
    expect_out("R3 busy beats disable", 1'b1, 4'd15, 9'h04F);
    drive(16'h0004, 17'h0, 4'd0, 1, 0, 0, 0);
    expect_out("R3 busy released", 1'b1, 4'd2, 9'h042);
  endtask

  task automatic t_nest();
    drive(16'h0020, 17'h0, 4'd0, 1, 0, 0, 9'h04A);
    expect_out("R7 trap level 0", 1'b1, 4'd5, 9'h045);
    drive(16'h0100, 17'h0, 4'd0, 1, 0, 1, 9'h04A);
    expect_out("R7 lower nested held", 1'b1, 4'd5, 9'h045);
    drive(16'h0100, 17'h0, 4'd0, 1, 0, 1, 9'h048);
    expect_out("R7 equal code taken", 1'b1, 4'd8, 9'h048);
    drive(16'h0020, 17'h0, 4'd0, 1, 0, 2, 9'h04A);
    expect_out("R7 held again", 1'b1, 4'd8, 9'h048);
    drive(16'h0020, 17'h0, 4'd0, 1, 0, 2, 9'h03A);
    expect_out("R7 outside group", 1'b1, 4'd5, 9'h045);
    drive(16'h0008, 17'h0, 4'd0, 1, 0, 0, 9'h04F);
    expect_out("R7 trap level cleared", 1'b1, 4'd3, 9'h043);
  endtask

  task automatic t_disable();
    drive(16'h0400, 17'h0, 4'd0, 0, 0, 0, 0);
    expect_out("R8 disabled clears", 1'b0, 4'd0, 9'h000);
    drive(16'h0400, 17'h0, 4'd0, 1, 0, 0, 0);
    expect_out("R9 re-request", 1'b1, 4'd10, 9'h04A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_merge();
    t_timer();
    t_scan();
    t_below();
    t_vec();
    t_nest();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule